// File: doc/BRIEF.md
# Non-Overlap Gate Sequencer with Zero-Crossing Cutoff

This block turns one raw pulse-width-modulated control signal into three switch commands for a synchronous buck power stage. One is for the high-side PMOS switch (active low), one for the low-side NMOS switch (active high), and one for a freewheel switch placed across the inductor. At every change of the PWM level, both power switches are first held off for a programmable dead time. Only then is the switch that the new level asks for turned on, so the two switches never conduct together.

In discontinuous-conduction operation, a comparator watching the switching node reports when the inductor current reaches zero. The sequencer passes that signal through a two-flop synchronizer. When DCM is enabled and the NMOS is conducting, it turns the NMOS off early and turns the freewheel switch on. The freewheel switch stays on until the PWM rises again. It is released before the PMOS dead time starts, so the freewheel switch and the PMOS are never on together.

All inputs are plain level control pins sampled on the rising clock edge. There is no data stream, so no valid/ready handshake and no back-pressure apply. Level shifting, gate buffering and the analog comparator sit outside this block.

Top module: `gate_seq`

## Requirements
- R1: While rst_n is low, hs_gate_n is 1, ls_gate is 0 and fw_en is 0. This also holds when reset is asserted in the middle of a switching period.
- R2: hs_gate_n is never 0 in a cycle where ls_gate is 1.
- R3: Call the edge where pwm_in is first sampled high edge 0, and the first later edge where it is sampled low edge H. If H > D, then hs_gate_n is 0 from edge 1+D through edge H, and is 1 again after edge H+1.
- R4: Using the edges of R3, ls_gate turns on after edge H+1+D. It turns off after the edge that follows the next sample of pwm_in high.
- R5: The dead time D is the value of the 2-bit dead_cfg (1, 2 or 3 clock cycles). The code 0 selects the default of 1 cycle.
- R6: If pwm_in stays high for H <= D samples, hs_gate_n stays 1 for the whole pulse, and ls_gate comes back on after edge H+1+D.
- R7: Suppose zcd_in is sampled high at edge Z, dcm_en is 1, and ls_gate was already 1 after edge Z+1. Then ls_gate goes to 0 and fw_en goes to 1 after edge Z+2.
- R8: A zcd_in pulse has no effect on any output when dcm_en is 0, or when ls_gate is 0 after edge Z+1.
- R9: fw_en stays 1 until the next sample of pwm_in high. It clears after the following edge, which is D cycles before hs_gate_n falls. fw_en is never 1 together with ls_gate or with hs_gate_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (one PWM time slot per cycle) |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | Raw PWM command, high asks for the high-side switch |
| zcd_in | input | 1 | Asynchronous zero-crossing comparator output, high at zero current |
| dcm_en | input | 1 | Enables zero-crossing cutoff and freewheeling |
| dead_cfg | input | 2 | Dead time in cycles, 0 selects 1 |
| hs_gate_n | output | 1 | High-side PMOS gate command, low turns the switch on |
| ls_gate | output | 1 | Low-side NMOS gate command, high turns the switch on |
| fw_en | output | 1 | Freewheel switch enable, high shorts the inductor |

## Verification
Each output is registered, so every result is counted from the edge at which a stimulus is sampled. A PWM change reaches the dead interval one edge later, passing through the input register and then the state register. The selected switch follows D edges after that. A zero-crossing pulse passes the two synchronizer flops before the state register acts on it, so it lands two edges after it is sampled. The bench drives inputs on the falling edge. For every cycle of a frame, it derives the expected level of each output from these edge counts, using the frame's high time, dead setting and pulse position. It compares at the following falling edge, half a cycle away from any edge where the design updates.

// File: rtl/gate_seq_pkg.sv
`timescale 1ns/1ps
package gate_seq_pkg;

  // Sequencer phases. Dead phases carry their target side in the name.
  typedef enum logic [2:0] {
    PH_DEAD_TO_LS = 3'd0,
    PH_DEAD_TO_HS = 3'd1,
    PH_HS_ON      = 3'd2,
    PH_LS_ON      = 3'd3,
    PH_FREEWHEEL  = 3'd4
  } gs_phase_e;

  // Registered gate command bundle.
  typedef struct packed {
    logic hs_n;
    logic ls;
    logic fw;
  } gs_gates_t;

  localparam gs_gates_t GATES_SAFE = '{hs_n: 1'b1, ls: 1'b0, fw: 1'b0};

  // Map a phase to the gate levels it asks for.
  function automatic gs_gates_t phase_gates(gs_phase_e ph);
    gs_gates_t g;
    g = GATES_SAFE;
    case (ph)
      PH_HS_ON:     g.hs_n = 1'b0;
      PH_LS_ON:     g.ls   = 1'b1;
      PH_FREEWHEEL: g.fw   = 1'b1;
      default:      g = GATES_SAFE;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/gate_seq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for an asynchronous single-bit level.
module gate_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/gate_seq_dead_timer.sv
`timescale 1ns/1ps
// Counts cycles spent in a dead phase. Restart loads one; done rises once
// the count reaches the effective dead time.
module gate_seq_dead_timer #(
  parameter int DT_W     = 2,
  parameter int DT_ZERO  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_cfg,
  input  logic            restart,
  output logic            done
);

  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);
  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};
  localparam logic [DT_W-1:0] CNT_DEF = DT_W'(DT_ZERO);

  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] dt_eff;

  // Code zero selects the default dead time.
  always_comb begin
    if (dead_cfg == '0) dt_eff = CNT_DEF;
    else                dt_eff = dead_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ONE;
    end else if (restart) begin
      cnt_q <= CNT_ONE;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  assign done = (cnt_q >= dt_eff);

endmodule

// File: rtl/gate_seq_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: dead-time insertion, zero-crossing cutoff and
// freewheel control, with registered glitch-free gate outputs.
module gate_seq_fsm
  import gate_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_q,
  input  logic zcd_s,
  input  logic dcm_en,
  input  logic dead_done,
  output logic dead_restart,
  output logic hs_gate_n,
  output logic ls_gate,
  output logic fw_en
);

  gs_phase_e ph_q, ph_d;
  gs_gates_t gates_q, gates_d;

  always_comb begin
    ph_d         = ph_q;
    dead_restart = 1'b0;
    case (ph_q)
      PH_HS_ON: begin
        if (!pwm_q) begin
          ph_d         = PH_DEAD_TO_LS;
          dead_restart = 1'b1;
        end
      end
      PH_LS_ON: begin
        if (pwm_q) begin
          ph_d         = PH_DEAD_TO_HS;
          dead_restart = 1'b1;
        end else if (dcm_en && zcd_s) begin
          ph_d = PH_FREEWHEEL;
        end
      end
      PH_FREEWHEEL: begin
        if (pwm_q) begin
          ph_d         = PH_DEAD_TO_HS;
          dead_restart = 1'b1;
        end
      end
      PH_DEAD_TO_HS: begin
        // A PWM reversal during the dead phase retargets and restarts it.
        if (!pwm_q) begin
          ph_d         = PH_DEAD_TO_LS;
          dead_restart = 1'b1;
        end else if (dead_done) begin
          ph_d = PH_HS_ON;
        end
      end
      PH_DEAD_TO_LS: begin
        if (pwm_q) begin
          ph_d         = PH_DEAD_TO_HS;
          dead_restart = 1'b1;
        end else if (dead_done) begin
          ph_d = PH_LS_ON;
        end
      end
      default: begin
        ph_d         = PH_DEAD_TO_LS;
        dead_restart = 1'b1;
      end
    endcase
  end

  assign gates_d = phase_gates(ph_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_DEAD_TO_LS;
      gates_q <= GATES_SAFE;
    end else begin
      ph_q    <= ph_d;
      gates_q <= gates_d;
    end
  end

  assign hs_gate_n = gates_q.hs_n;
  assign ls_gate   = gates_q.ls;
  assign fw_en     = gates_q.fw;

endmodule

// File: rtl/gate_seq.sv
`timescale 1ns/1ps
// Non-overlap gate sequencer with zero-crossing cutoff (top level).
module gate_seq #(
  parameter int DT_W        = 2,
  parameter int DT_ZERO     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_in,
  input  logic            zcd_in,
  input  logic            dcm_en,
  input  logic [DT_W-1:0] dead_cfg,
  output logic            hs_gate_n,
  output logic            ls_gate,
  output logic            fw_en
);

  logic pwm_q;
  logic zcd_s;
  logic dead_done;
  logic dead_restart;

  // PWM comes from the same clock domain; one register aligns it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_in;
  end

  gate_seq_sync #(.STAGES(SYNC_STAGES)) u_zcd_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (zcd_in),
    .q_sync  (zcd_s)
  );

  gate_seq_dead_timer #(.DT_W(DT_W), .DT_ZERO(DT_ZERO)) u_dead (
    .clk      (clk),
    .rst_n    (rst_n),
    .dead_cfg (dead_cfg),
    .restart  (dead_restart),
    .done     (dead_done)
  );

  gate_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_q        (pwm_q),
    .zcd_s        (zcd_s),
    .dcm_en       (dcm_en),
    .dead_done    (dead_done),
    .dead_restart (dead_restart),
    .hs_gate_n    (hs_gate_n),
    .ls_gate      (ls_gate),
    .fw_en        (fw_en)
  );

endmodule

// File: rtl/gate_seq_chk.sv
`timescale 1ns/1ps
module gate_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic dcm_en,
  input logic hs_gate_n,
  input logic ls_gate,
  input logic fw_en
);

  AST_RESET_SAFE: assert property (@(posedge clk) !rst_n |=> (hs_gate_n && !ls_gate && !fw_en)); // R1

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(!hs_gate_n && ls_gate)); // R2

  AST_HS_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n) $fell(hs_gate_n) |-> ($past(!ls_gate) && $past(!fw_en))); // R3

  AST_LS_AFTER_DEAD: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_gate) |-> $past(hs_gate_n)); // R4

  AST_FW_FROM_LS: assert property (@(posedge clk) disable iff (!rst_n) $rose(fw_en) |-> ($past(ls_gate) && $past(dcm_en))); // R8

  AST_FW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) fw_en |-> (hs_gate_n && !ls_gate)); // R9

endmodule

bind gate_seq gate_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dcm_en    (dcm_en),
  .hs_gate_n (hs_gate_n),
  .ls_gate   (ls_gate),
  .fw_en     (fw_en)
);

// File: tb/gate_seq_tb.sv
`timescale 1ns/1ps
module gate_seq_tb;

  localparam int FR     = 16;      // frame length in cycles
  localparam int WD_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in;
  logic       zcd_in;
  logic       dcm_en;
  logic [1:0] dead_cfg;
  logic       hs_gate_n;
  logic       ls_gate;
  logic       fw_en;

  int  vecs = 0;
  int  errs = 0;
  bit  done_flag = 1'b0;

  always #2.5 clk = ~clk;

  gate_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_in    (pwm_in),
    .zcd_in    (zcd_in),
    .dcm_en    (dcm_en),
    .dead_cfg  (dead_cfg),
    .hs_gate_n (hs_gate_n),
    .ls_gate   (ls_gate),
    .fw_en     (fw_en)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One frame: pwm high for samples [0,h), zcd pulse at sample z (z<0: none).
  task automatic run_trial(int cfg, int h, int dcm, int z);
    int  dt;
    bit  zc;
    bit  hs_exp, ls_exp, fw_exp;
    string tag_hs, tag_ls, tag_fw;
    dt = (cfg == 0) ? 1 : cfg;              // R5 default when code is zero
    zc = (dcm != 0) && (z >= 0) && (z >= h + dt) && (z + 2 <= FR);
    dead_cfg = 2'(cfg);
    dcm_en   = (dcm != 0);
    tag_hs = (cfg == 0) ? "R5" : ((h <= dt) ? "R6" : "R3");
    tag_ls = zc ? "R7" : ((z >= 0) ? "R8" : "R4");
    tag_fw = zc ? "R9" : "R8";
    for (int k = 0; k <= FR + 1; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        int idx;
        idx    = k - 1;
        hs_exp = (idx >= 1 + dt) && (idx <= h);
        fw_exp = zc && (idx >= z + 2);
        ls_exp = (idx >= h + 1 + dt) && !fw_exp;
        chk(tag_hs, "hs_gate_n", hs_gate_n, !hs_exp);
        chk(tag_ls, "ls_gate", ls_gate, ls_exp);
        chk(tag_fw, "fw_en", fw_en, fw_exp);
        chk("R2", "overlap", (!hs_gate_n && ls_gate), 1'b0);
      end
      pwm_in = (k < h);
      zcd_in = (k == z);
    end
  endtask

  initial begin
    rst_n    = 1'b0;
    pwm_in   = 1'b1;
    zcd_in   = 1'b1;
    dcm_en   = 1'b1;
    dead_cfg = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset holds every switch off despite active inputs
    chk("R1", "hs_gate_n", hs_gate_n, 1'b1);
    chk("R1", "ls_gate", ls_gate, 1'b0);
    chk("R1", "fw_en", fw_en, 1'b0);
    pwm_in = 1'b0;
    zcd_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int hs = 0; hs < 4; hs++) begin
        for (int dcm = 0; dcm < 2; dcm++) begin
          for (int zs = 0; zs < 6; zs++) begin
            int dt, h, z;
            dt = (cfg == 0) ? 1 : cfg;
            case (hs)
              0: h = 1;
              1: h = dt;
              2: h = dt + 1;
              default: h = 7;
            endcase
            case (zs)
              0: z = -1;
              1: z = 1;
              2: z = h + dt - 1;
              3: z = h + dt;
              4: z = h + dt + 3;
              default: z = FR - 2;
            endcase
            run_trial(cfg, h, dcm, z);
          end
        end
      end
    end

    // R1: reset asserted mid-period while the PMOS is on
    dead_cfg = 2'd2;
    dcm_en   = 1'b0;
    pwm_in   = 1'b1;
    repeat (10) @(negedge clk);
    chk("R3", "hs_gate_n before reset", hs_gate_n, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1", "hs_gate_n", hs_gate_n, 1'b1);
    chk("R1", "ls_gate", ls_gate, 1'b0);
    chk("R1", "fw_en", fw_en, 1'b0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(WD_CYC * 5.0);
    if (!done_flag) begin
      done_flag = 1'b1;
      vecs++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule